// File: doc/BRIEF.md
# Port-Mapped I/O Cycle Sequencer

This block runs one port-mapped I/O transaction on a shared 16-bit bus made of two 8-bit halves, H and L. A start strobe brings in an I/O instruction byte, the accumulator value and an output data byte. The instruction's upper four bits select the kind of operation. Its lower four bits are a free field whose meaning the program and the device agree on between them.

Once a transaction starts, the sequencer walks through four phases, one clock each. In the command phase it drives the low six instruction bits on H and the accumulator on L, so that the device can decode an ad-hoc command. In the next phase an output operation drives its data byte on L. In the third phase the sequencer releases the bus and samples the device's reply into a read register. The fourth phase closes the cycle and raises a done strobe. A one-hot phase output tells attached devices which phase is current.

Top module: `iox_sequencer`

## Requirements
- R1: After reset, phase_o is 0, busy_o, done_o and bus_oe_o are 0, bus_h_o and bus_l_o are 0, and rdata_o is 0.
- R2: A start_i seen high at a clock edge while idle begins a transaction, and phase_o reads 4'b0001 after that edge.
- R3: phase_o steps 4'b0001, 4'b0010, 4'b0100, 4'b1000 on consecutive clocks and then returns to 0, so every transaction holds busy_o for exactly four cycles.
- R4: In phase 1 (phase_o = 4'b0001), bus_h_o is instr_i[5:0] with two zero bits above it, bus_l_o is the accumulator, and bus_oe_o is 1. All operands are the values present with the accepted start.
- R5: In phase 2 (4'b0010) of an output operation (opcode instr[7:4] = 4'h1), bus_l_o carries the output byte, bus_h_o is 0 and bus_oe_o is 1.
- R6: In phase 2 of any operation other than output, bus_oe_o is 0 and both bus halves read 0.
- R7: In phase 3 (4'b0100), bus_oe_o is 0. For an input operation (opcode 4'h2) or a status operation (opcode 4'h3), bus_l_i is sampled at the clock edge that ends phase 3, and rdata_o shows it from phase 4 on.
- R8: For every opcode other than 4'h2 and 4'h3, rdata_o keeps its previous value through the whole transaction.
- R9: done_o is 1 only in phase 4 (4'b1000). On the next clock busy_o, bus_oe_o and phase_o are all 0.
- R10: A start_i seen while busy_o is 1 is ignored. The running transaction completes unchanged, and no new one follows it.
- R11: While idle and in phase 4, bus_oe_o is 0 and both bus halves read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transaction start strobe |
| instr_i | input | 8 | I/O instruction: opcode [7:4], free field [3:0] |
| acc_i | input | 8 | Accumulator value for phase 1 |
| wdata_i | input | 8 | Output data for phase 2 |
| bus_l_i | input | 8 | L half of the bus as driven by the device |
| bus_h_o | output | 8 | H half driven by the sequencer |
| bus_l_o | output | 8 | L half driven by the sequencer |
| bus_oe_o | output | 1 | Sequencer drives the bus |
| phase_o | output | 4 | One-hot current phase, 0 when idle |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Completion strobe in phase 4 |
| rdata_o | output | 8 | Data captured from the device |

## Verification
The main function is run with an output operation, an input operation, a status operation and an unassigned opcode. Between them, these separate the phase-2 drive from the phase-2 release and separate capture from hold. Operand inputs are changed once a start has been accepted, which tells latched operands apart from live ones. An all-ones instruction shows that only six bits reach H. A second start strobe in the middle of a transaction, followed by back-to-back transactions, checks that a strobe is ignored while busy and still honoured as soon as the block is idle again.

// File: rtl/iox_pkg.sv
package iox_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_OUT  = 4'h1;
  localparam logic [OP_W-1:0] OP_IN   = 4'h2;
  localparam logic [OP_W-1:0] OP_STAT = 4'h3;
  localparam int N_PH = 4;

  function automatic logic is_out(input logic [OP_W-1:0] op);
    return op == OP_OUT;
  endfunction

  function automatic logic is_in(input logic [OP_W-1:0] op);
    return (op == OP_IN) || (op == OP_STAT);
  endfunction
endpackage

// File: rtl/iox_phase_ctrl.sv
module iox_phase_ctrl
  import iox_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  output logic            accept_o,
  output logic [N_PH-1:0] phase_o
);
  logic [N_PH-1:0] phase_q;

  assign accept_o = start_i && (phase_q == '0);
  assign phase_o  = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (accept_o) begin
      phase_q <= {{(N_PH-1){1'b0}}, 1'b1};
    end else begin
      phase_q <= {phase_q[N_PH-2:0], 1'b0};
    end
  end

  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase_q));
  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    phase_q[0] |=> phase_q[1]);
  p_end_r9: assert property (@(posedge clk) disable iff (rst)
    phase_q[N_PH-1] |=> (phase_q == '0));
  p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (start_i && (phase_q != '0)) |=> !phase_q[0]);
endmodule

// File: rtl/iox_bus_drive.sv
module iox_bus_drive
  import iox_pkg::*;
#(
  parameter int IW   = 8,
  parameter int DW   = 8,
  parameter int CMDW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept_i,
  input  logic            ph1_i,
  input  logic            ph2_i,
  input  logic [IW-1:0]   instr_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [OP_W-1:0] op_o,
  output logic [DW-1:0]   h_o,
  output logic [DW-1:0]   l_o,
  output logic            oe_o
);
  logic [OP_W-1:0] op_q;
  logic [DW-1:0]   wdata_q, h_q, l_q;
  logic            oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= '0;
      wdata_q <= '0;
      h_q     <= '0;
      l_q     <= '0;
      oe_q    <= 1'b0;
    end else if (accept_i) begin
      op_q    <= instr_i[IW-1 -: OP_W];
      wdata_q <= wdata_i;
      h_q     <= {{(DW-CMDW){1'b0}}, instr_i[CMDW-1:0]};
      l_q     <= acc_i;
      oe_q    <= 1'b1;
    end else if (ph1_i && is_out(op_q)) begin
      h_q  <= '0;
      l_q  <= wdata_q;
      oe_q <= 1'b1;
    end else begin
      h_q  <= '0;
      l_q  <= '0;
      oe_q <= 1'b0;
    end
  end

  assign op_o = op_q;
  assign h_o  = h_q;
  assign l_o  = l_q;
  assign oe_o = oe_q;

  p_cmd_drive_r4: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> (oe_q && (l_q == $past(acc_i))));
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    ph2_i |=> !oe_q);
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (ph1_i && !is_out(op_q)) |=> (!oe_q && (l_q == '0)));
endmodule

// File: rtl/iox_capture.sv
module iox_capture
  import iox_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ph3_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   bus_l_i,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (ph3_i && is_in(op_i)) begin
      rdata_q <= bus_l_i;
    end
  end

  assign rdata_o = rdata_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(ph3_i && is_in(op_i)) |=> $stable(rdata_q));
  p_sample_r7: assert property (@(posedge clk) disable iff (rst)
    (ph3_i && is_in(op_i)) |=> (rdata_q == $past(bus_l_i)));
endmodule

// File: rtl/iox_sequencer.sv
module iox_sequencer
  import iox_pkg::*;
#(
  parameter int IW   = 8,
  parameter int DW   = 8,
  parameter int CMDW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [IW-1:0]   instr_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   bus_l_i,
  output logic [DW-1:0]   bus_h_o,
  output logic [DW-1:0]   bus_l_o,
  output logic            bus_oe_o,
  output logic [N_PH-1:0] phase_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o
);
  logic            accept;
  logic [N_PH-1:0] phase;
  logic [OP_W-1:0] op;

  iox_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .accept_o (accept),
    .phase_o  (phase)
  );

  iox_bus_drive #(.IW(IW), .DW(DW), .CMDW(CMDW)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .ph1_i    (phase[0]),
    .ph2_i    (phase[1]),
    .instr_i  (instr_i),
    .acc_i    (acc_i),
    .wdata_i  (wdata_i),
    .op_o     (op),
    .h_o      (bus_h_o),
    .l_o      (bus_l_o),
    .oe_o     (bus_oe_o)
  );

  iox_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .ph3_i   (phase[2]),
    .op_i    (op),
    .bus_l_i (bus_l_i),
    .rdata_o (rdata_o)
  );

  assign phase_o = phase;
  assign busy_o  = |phase;
  assign done_o  = phase[N_PH-1];

  p_phase3_float_r7: assert property (@(posedge clk) disable iff (rst)
    phase_o[2] |-> !bus_oe_o);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (phase_o == '0) |-> (!bus_oe_o && bus_h_o == '0 && bus_l_o == '0));
  p_done_once_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (phase_o == 4'b0001));
endmodule

// File: tb/iox_sequencer_test.sv
module iox_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] instr_i = '0, acc_i = '0, wdata_i = '0, bus_l_i = '0;
  logic [7:0] bus_h_o, bus_l_o, rdata_o;
  logic       bus_oe_o, busy_o, done_o;
  logic [3:0] phase_o;

  typedef struct {
    logic [29:0] v;
    string       tag;
  } item_t;

  item_t      sb[$];
  int         checks = 0;
  int         errors = 0;
  logic [7:0] model_rd = '0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  iox_sequencer uut (
    .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i),
    .acc_i(acc_i), .wdata_i(wdata_i), .bus_l_i(bus_l_i),
    .bus_h_o(bus_h_o), .bus_l_o(bus_l_o), .bus_oe_o(bus_oe_o),
    .phase_o(phase_o), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
  );

  function automatic logic [29:0] snap();
    return {phase_o, bus_h_o, bus_l_o, bus_oe_o, done_o, rdata_o};
  endfunction

  task automatic check(input string tag, input logic [29:0] got, input logic [29:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got ph=%b h=%h l=%h oe=%b dn=%b rd=%h  exp ph=%b h=%h l=%h oe=%b dn=%b rd=%h",
               tag, got[29:26], got[25:18], got[17:10], got[9], got[8], got[7:0],
               exp[29:26], exp[25:18], exp[17:10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  // monitor: one expected item per busy cycle
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && busy_o) begin
        if (sb.size() == 0) begin
          check("R10 unexpected busy cycle", snap(), '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, snap(), it.v);
        end
      end
    end
  end

  task automatic run_io(input logic [7:0] ins, input logic [7:0] acc,
                        input logic [7:0] wd, input logic [7:0] din,
                        input bit poke);
    logic [3:0] op;
    item_t it;
    op = ins[7:4];
    @(negedge clk);
    instr_i = ins; acc_i = acc; wdata_i = wd; bus_l_i = din; start_i = 1'b1;
    it.v = {4'b0001, {2'b00, ins[5:0]}, acc, 1'b1, 1'b0, model_rd};
    it.tag = "R2 R4 phase1"; sb.push_back(it);
    if (op == 4'h1) begin
      it.v = {4'b0010, 8'h00, wd, 1'b1, 1'b0, model_rd}; it.tag = "R5 out phase2";
    end else begin
      it.v = {4'b0010, 8'h00, 8'h00, 1'b0, 1'b0, model_rd}; it.tag = "R6 no-out phase2";
    end
    sb.push_back(it);
    it.v = {4'b0100, 8'h00, 8'h00, 1'b0, 1'b0, model_rd}; it.tag = "R7 phase3 release";
    sb.push_back(it);
    if (op == 4'h2 || op == 4'h3) model_rd = din;
    it.v = {4'b1000, 8'h00, 8'h00, 1'b0, 1'b1, model_rd}; it.tag = "R7 R8 R9 phase4";
    sb.push_back(it);
    @(negedge clk);                       // phase 1 visible
    start_i = 1'b0;
    instr_i = ~ins; acc_i = ~acc; wdata_i = ~wd;   // operands must be latched
    @(negedge clk);                       // phase 2
    if (poke) start_i = 1'b1;
    @(negedge clk);                       // phase 3
    start_i = 1'b0;
    @(negedge clk);                       // phase 4
    bus_l_i = ~din;
    @(negedge clk);                       // idle
    check("R3 R9 R10 R11 idle after end", snap(),
          {4'b0000, 8'h00, 8'h00, 1'b0, 1'b0, model_rd});
    checks++;
    if (busy_o !== 1'b0) begin
      errors++;
      $display("FAIL R3: busy_o got %b exp 0", busy_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", snap(), '0);
    checks++;
    if (busy_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: busy_o got %b exp 0", busy_o);
    end
    run_io(8'h1A, 8'h5C, 8'hE7, 8'h33, 1'b0);  // output op
    run_io(8'h2F, 8'h81, 8'h11, 8'h96, 1'b0);  // input op
    run_io(8'h35, 8'h00, 8'h22, 8'h4B, 1'b0);  // status op
    run_io(8'h9C, 8'hFF, 8'h3C, 8'hFF, 1'b0);  // unassigned opcode
    run_io(8'h27, 8'h42, 8'h99, 8'hA5, 1'b1);  // input op, start poked mid-way
    run_io(8'hFF, 8'h0F, 8'h77, 8'h01, 1'b0);  // all-ones instruction
    run_io(8'h13, 8'hC3, 8'h5A, 8'hEE, 1'b0);  // output, rdata held
    repeat (2) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d expected phases never seen, exp 0", sb.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule